// File: doc/BRIEF.md
# Paged Subroutine Call Sequencer

This block carries out the stack and register work of a call into banked (paged) program memory. On a start strobe it captures the return address, the already-resolved 16-bit target address, the target page byte, the current stack pointer and the current page register. It then writes a three-byte call frame onto a stack that grows toward lower addresses, one byte per clock. The return address goes first, high byte then low byte, followed by the old page value. In one final clock it loads the new page register, the new program counter and the new stack pointer together.

Operand decoding is done upstream. The extended form of the call carries the address high byte, the address low byte and then the page byte. The indexed forms reach this block with the same resolved operands. The surrounding core holds its fetch while `busy` is high and takes `spOut`, `pageOut` and `pcOut` as its new architectural state.

Top module: `paged_call_seq`

## Requirements
- R1: While reset is low and in the first cycle after it, busy and stackWe are 0, and spOut, pageOut and pcOut are all 0.
- R2: A start pulse seen while idle makes busy rise on the next clock. Busy then stays high for exactly four cycles: three write cycles and one load cycle. It falls on the clock that updates the outputs.
- R3: The first stack write puts retAddr[15:8] at address spIn-2.
- R4: The second stack write, in the next cycle, puts retAddr[7:0] at address spIn-1.
- R5: The third stack write, in the next cycle, puts the captured pageIn value at address spIn-3.
- R6: stackWe is high in exactly the three write cycles of a call and low in every other cycle.
- R7: pcOut becomes targetAddr, pageOut becomes targetPage and spOut becomes spIn-3, all on the same clock edge. None of the three changes at any other edge.
- R8: All stack pointer arithmetic wraps modulo 2^16. For example, spIn=0x0001 writes to 0xFFFF, 0x0000 and 0xFFFE, and leaves spOut=0xFFFE.
- R9: Start pulses and input changes while busy is high are ignored. The frame and the loaded values all come from the inputs sampled with the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a call when idle |
| retAddr | input | 16 | Return address to save |
| targetAddr | input | 16 | Resolved subroutine address |
| targetPage | input | 8 | New page register value |
| spIn | input | 16 | Stack pointer before the call |
| pageIn | input | 8 | Page register before the call |
| busy | output | 1 | Call in progress |
| stackWe | output | 1 | Stack byte write enable |
| stackAddr | output | 16 | Stack byte address |
| stackData | output | 8 | Stack byte value |
| spOut | output | 16 | Stack pointer after the last call |
| pageOut | output | 8 | Page register after the last call |
| pcOut | output | 16 | Program counter after the last call |

## Verification
The assertions assume that start is a clean synchronous level and that the stack write port accepts one byte every cycle with no back-pressure. The bench meets both by changing inputs only on the falling edge. It also drives no memory-side stall, because the block has none. It scrambles retAddr, spIn and the other operands, and pulses start, while a call is in flight. This shows that the checks hold even when the inputs are not held steady during a call.

// File: rtl/paged_call_pkg.sv
package paged_call_pkg;
  localparam int SLOT_BITS = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_LOAD = 2'd2
  } seqState_t;

  typedef struct packed {
    logic                 capture;
    logic                 push;
    logic [SLOT_BITS-1:0] slot;
    logic                 commit;
  } seqStrobe_t;
endpackage

// File: rtl/paged_call_ctrl.sv
module paged_call_ctrl
  import paged_call_pkg::*;
#(
  parameter int RET_BYTES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       busy,
  output seqStrobe_t strobe
);
  localparam logic [SLOT_BITS-1:0] LAST_SLOT = SLOT_BITS'(RET_BYTES);

  seqState_t            state;
  logic [SLOT_BITS-1:0] slotCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      slotCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state   <= ST_PUSH;
          slotCnt <= '0;
        end
        ST_PUSH: begin
          if (slotCnt == LAST_SLOT) state <= ST_LOAD;
          else slotCnt <= slotCnt + 1'b1;
        end
        ST_LOAD: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy           = (state != ST_IDLE);
    strobe.capture = (state == ST_IDLE) && start;
    strobe.push    = (state == ST_PUSH);
    strobe.slot    = slotCnt;
    strobe.commit  = (state == ST_LOAD);
  end
endmodule

// File: rtl/paged_call_dp.sv
module paged_call_dp
  import paged_call_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] retAddr,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic [BYTE_W-1:0] targetPage,
  input  logic [ADDR_W-1:0] spIn,
  input  logic [BYTE_W-1:0] pageIn,
  output logic              stackWe,
  output logic [ADDR_W-1:0] stackAddr,
  output logic [BYTE_W-1:0] stackData,
  output logic [ADDR_W-1:0] spOut,
  output logic [BYTE_W-1:0] pageOut,
  output logic [ADDR_W-1:0] pcOut
);
  localparam int RET_BYTES = ADDR_W / BYTE_W;
  localparam logic [ADDR_W-1:0] RET_SPAN   = ADDR_W'(RET_BYTES);
  localparam logic [ADDR_W-1:0] FRAME_SPAN = ADDR_W'(RET_BYTES + 1);

  logic [ADDR_W-1:0] retLat, tgtLat, spLat;
  logic [BYTE_W-1:0] tpgLat, pgLat;
  logic [BYTE_W-1:0] retBytes [RET_BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      retLat <= '0;
      tgtLat <= '0;
      spLat  <= '0;
      tpgLat <= '0;
      pgLat  <= '0;
    end else if (strobe.capture) begin
      retLat <= retAddr;
      tgtLat <= targetAddr;
      spLat  <= spIn;
      tpgLat <= targetPage;
      pgLat  <= pageIn;
    end
  end

  // Split the return address into bytes, most significant byte first.
  for (genvar gi = 0; gi < RET_BYTES; gi++) begin : g_retByte
    assign retBytes[gi] = retLat[ADDR_W-1-gi*BYTE_W -: BYTE_W];
  end

  always_comb begin
    stackWe = strobe.push;
    if (int'(strobe.slot) < RET_BYTES) begin
      stackAddr = spLat - RET_SPAN + ADDR_W'(strobe.slot);
      stackData = retBytes[strobe.slot[$clog2(RET_BYTES+1)-1:0]];
    end else begin
      stackAddr = spLat - FRAME_SPAN;
      stackData = pgLat;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spOut   <= '0;
      pageOut <= '0;
      pcOut   <= '0;
    end else if (strobe.commit) begin
      spOut   <= spLat - FRAME_SPAN;
      pageOut <= tpgLat;
      pcOut   <= tgtLat;
    end
  end
endmodule

// File: rtl/paged_call_seq.sv
module paged_call_seq
  import paged_call_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] retAddr,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic [BYTE_W-1:0] targetPage,
  input  logic [ADDR_W-1:0] spIn,
  input  logic [BYTE_W-1:0] pageIn,
  output logic              busy,
  output logic              stackWe,
  output logic [ADDR_W-1:0] stackAddr,
  output logic [BYTE_W-1:0] stackData,
  output logic [ADDR_W-1:0] spOut,
  output logic [BYTE_W-1:0] pageOut,
  output logic [ADDR_W-1:0] pcOut
);
  localparam int RET_BYTES = ADDR_W / BYTE_W;

  seqStrobe_t strobe;

  paged_call_ctrl #(.RET_BYTES(RET_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .strobe(strobe)
  );

  paged_call_dp #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .retAddr(retAddr), .targetAddr(targetAddr), .targetPage(targetPage),
    .spIn(spIn), .pageIn(pageIn),
    .stackWe(stackWe), .stackAddr(stackAddr), .stackData(stackData),
    .spOut(spOut), .pageOut(pageOut), .pcOut(pcOut)
  );
endmodule

// File: rtl/paged_call_seq_chk.sv
module paged_call_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              stackWe,
  input logic [ADDR_W-1:0] stackAddr,
  input logic [BYTE_W-1:0] stackData,
  input logic [ADDR_W-1:0] spOut,
  input logic [BYTE_W-1:0] pageOut,
  input logic [ADDR_W-1:0] pcOut
);
  logic unusedData;
  assign unusedData = ^stackData;

  p_start_begins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && stackWe));

  p_write_only_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stackWe |-> busy);

  p_return_bytes_adjacent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stackWe) |=> (stackWe && stackAddr == $past(stackAddr) + 1'b1));

  p_load_then_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !stackWe) |=> !busy);

  p_state_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(spOut) && $stable(pageOut) && $stable(pcOut)));

  p_state_held_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stackWe |=> ($stable(spOut) && $stable(pageOut) && $stable(pcOut)));
endmodule

bind paged_call_seq paged_call_seq_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .stackWe(stackWe),
  .stackAddr(stackAddr), .stackData(stackData), .spOut(spOut),
  .pageOut(pageOut), .pcOut(pcOut)
);

// File: tb/paged_call_seq_bench.sv
module paged_call_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] retAddr = '0, targetAddr = '0, spIn = '0;
  logic [7:0]  targetPage = '0, pageIn = '0;
  logic        busy, stackWe;
  logic [15:0] stackAddr, spOut, pcOut;
  logic [7:0]  stackData, pageOut;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  paged_call_seq u_paged_call_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .retAddr(retAddr),
    .targetAddr(targetAddr), .targetPage(targetPage), .spIn(spIn), .pageIn(pageIn),
    .busy(busy), .stackWe(stackWe), .stackAddr(stackAddr), .stackData(stackData),
    .spOut(spOut), .pageOut(pageOut), .pcOut(pcOut)
  );

  // Behavioural reference: phase 0 idle, 1..3 frame bytes, 4 load.
  int          mPhase = 0;
  logic [15:0] mRet, mTgt, mSp, mSpOut = '0, mPc = '0;
  logic [7:0]  mTpg, mPg, mPgOut = '0;
  logic [7:0]  stackMem [logic [15:0]];

  always @(posedge clk) begin
    if (stackWe) stackMem[stackAddr] = stackData;
    if (!rst_n) begin
      mPhase = 0; mSpOut = '0; mPc = '0; mPgOut = '0;
    end else if (mPhase == 0) begin
      if (start) begin
        mRet = retAddr; mTgt = targetAddr; mSp = spIn; mTpg = targetPage; mPg = pageIn;
        mPhase = 1;
      end
    end else if (mPhase == 4) begin
      mPc = mTgt; mPgOut = mTpg; mSpOut = mSp - 16'd3;
      mPhase = 0;
    end else begin
      mPhase = mPhase + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare every cycle against the model.
  task automatic compareNow();
    logic expWe;
    expWe = (mPhase >= 1 && mPhase <= 3);
    check("R2 busy", 32'(busy), 32'(mPhase != 0));
    check("R6 stackWe", 32'(stackWe), 32'(expWe));
    if (mPhase == 1) begin
      check("R3 addr", 32'(stackAddr), 32'(16'(mSp - 16'd2)));
      check("R3 data", 32'(stackData), 32'(mRet[15:8]));
    end
    if (mPhase == 2) begin
      check("R4 addr", 32'(stackAddr), 32'(16'(mSp - 16'd1)));
      check("R4 data", 32'(stackData), 32'(mRet[7:0]));
    end
    if (mPhase == 3) begin
      check("R5 addr", 32'(stackAddr), 32'(16'(mSp - 16'd3)));
      check("R5 data", 32'(stackData), 32'(mPg));
    end
    check("R7 spOut", 32'(spOut), 32'(mSpOut));
    check("R7 pageOut", 32'(pageOut), 32'(mPgOut));
    check("R7 pcOut", 32'(pcOut), 32'(mPc));
  endtask

  task automatic tick();
    @(negedge clk);
    compareNow();
  endtask

  task automatic callOnce(input logic [15:0] ra, input logic [15:0] ta,
                          input logic [7:0] tp, input logic [15:0] sp,
                          input logic [7:0] pg, input bit scramble);
    retAddr = ra; targetAddr = ta; targetPage = tp; spIn = sp; pageIn = pg;
    start = 1'b1;
    tick();
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (scramble) begin
        // R9: stray starts and changed operands while busy must be ignored.
        start = 1'b1; retAddr = ~ra; spIn = sp ^ 16'h5A5A; pageIn = ~pg;
        targetAddr = ta + 16'd7; targetPage = tp ^ 8'hFF;
      end
      tick();
    end
    start = 1'b0;
    tick();
    check("R3 stack hi", 32'(stackMem[16'(sp - 16'd2)]), 32'(ra[15:8]));
    check("R4 stack lo", 32'(stackMem[16'(sp - 16'd1)]), 32'(ra[7:0]));
    check("R5 stack page", 32'(stackMem[16'(sp - 16'd3)]), 32'(pg));
    check("R7 final pc", 32'(pcOut), 32'(ta));
    check("R7 final page", 32'(pageOut), 32'(tp));
    check("R8 final sp", 32'(spOut), 32'(16'(sp - 16'd3)));
    check("R9 idle after call", 32'(busy), 32'd0);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 stackWe", 32'(stackWe), 32'd0);
        check("R1 outs", 32'({spOut, pcOut} | 32'(pageOut)), 32'd0);
        tick();
        rst_n = 1'b1;
        tick();
        check("R1 after release", 32'(spOut | pcOut | 16'(pageOut)), 32'd0);
        callOnce(16'h1234, 16'h8000, 8'h3C, 16'h0400, 8'h01, 1'b0);
        callOnce(16'hBEEF, 16'h9ABC, 8'h7F, 16'h3FFD, 8'h3C, 1'b1);
        callOnce(16'h00FF, 16'hFFFF, 8'h00, 16'h0001, 8'hA5, 1'b0);
        callOnce(16'hFF00, 16'h0000, 8'hFF, 16'h0000, 8'h5A, 1'b1);
        callOnce(16'hC0DE, 16'h4321, 8'h12, 16'h0002, 8'h99, 1'b0);
        // Held start: a second call begins once idle.
        retAddr = 16'hA1B2; targetAddr = 16'h2222; targetPage = 8'h44;
        spIn = 16'h2000; pageIn = 8'h66; start = 1'b1;
        for (int i = 0; i < 12; i++) tick();
        start = 1'b0;
        for (int i = 0; i < 6; i++) tick();
        check("R8 held start sp", 32'(spOut), 32'h1FFD);
        // Idle with changing inputs: outputs hold.
        for (int i = 0; i < 8; i++) begin
          spIn = 16'(i * 37); targetAddr = 16'(i * 91);
          tick();
        end
        check("R7 idle hold pc", 32'(pcOut), 32'h2222);
      end
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule